// File: doc/BRIEF.md
# Processor Management Register Slave

This block is a small memory-mapped register slave that a host processor, or a bridge in front of one, reaches through a four-signal handshake. The master places an address and a direction flag on the bus and raises a request. For a store it also supplies a 32-bit word. The slave finishes the access with a one-cycle acknowledge. For a load, the acknowledge comes with the selected word on the read-data bus. Everything runs on one management clock.

The block holds `NUM_CTRL` read/write control words at the lowest word addresses. The word directly above them is a read-only copy of a status input. The `RATE_SEL` parameter sets the address width from the set of line rates that must be supported:

| `RATE_SEL` | Rate set | Address width |
|---|---|---|
| 0 | Basic rates | 4 bits |
| 1 | Intermediate rates | 5 bits |
| 2 | Top rate | 8 bits |

Every address bit is decoded, so no register appears at more than one address. The master must drop its request for at least one cycle between two accesses. A request that is held high is served only once.

Top module: `mgmt_reg_slave`

## Requirements
- R1: `bus_ack` is high for exactly one cycle. It rises on the clock edge after the one at which a new request is sampled, and it is never high unless `bus_req` was high at the previous edge.
- R2: With `bus_rnw` = 0 (write), the word on `bus_wdata` is stored in control word n when `bus_addr` = n, for n < `NUM_CTRL`. A later access with `bus_rnw` = 1 (read) at that address returns the stored word.
- R3: `bus_rdata` changes only in a cycle in which `bus_ack` is high after a read. It keeps the last read value through writes and idle cycles.
- R4: A request held high over many cycles produces a single acknowledge and a single access. A new access starts only after `bus_req` has been sampled low.
- R5: A write to any address above `NUM_CTRL` leaves every control word unchanged. A read from such an address returns zero.
- R6: A read from address `NUM_CTRL` returns `status_in`, registered once and zero-extended to 32 bits. A write to that address changes nothing.
- R7: A synchronous active-high `rst` clears all control words, `bus_ack` and `bus_rdata` to zero. After reset the first access is accepted only once `bus_req` has been seen low.
- R8: The address width is 4, 5 or 8 bits for `RATE_SEL` 0, 1 or 2. All bits of the address are decoded, so an address that matches a mapped word only in its low bits is treated as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address (4, 5 or 8 bits per `RATE_SEL`) |
| bus_req | input | 1 | Access request, level; must go low between accesses |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | DATA_W | Write word (32 bits) |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | DATA_W | Read word, valid with `bus_ack`, held until the next read |
| status_in | input | STAT_W | Status bits mirrored into the read-only word |

## Verification
A corrupted control word shows up on the read bus in the acknowledge cycle of the next read of that address. The sweep reads every address after storing a distinct pattern at each one, so a decode fault or an alias appears within one pass. A stuck or re-armed handshake state appears as a missing or repeated acknowledge within two cycles of the request edge. A read-path fault appears as `bus_rdata` changing across a write or idle stretch.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  // Line-rate set selector values
  localparam int RATE_BASIC = 0;
  localparam int RATE_MID   = 1;
  localparam int RATE_TOP   = 2;

  function automatic int addr_w_for(input int rate_sel);
    case (rate_sel)
      RATE_TOP: return 8;
      RATE_MID: return 5;
      default:  return 4;
    endcase
  endfunction

endpackage

// File: rtl/mgmt_handshake.sv
module mgmt_handshake (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept,
  output logic ack
);

  logic armed_q;

  // A request is taken only when the slave was re-armed by a low sample
  assign accept = req & armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      ack     <= 1'b0;
    end else begin
      ack <= accept;
      if (accept)
        armed_q <= 1'b0;
      else if (!req)
        armed_q <= 1'b1;
    end
  end

  p_ack_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  p_ack_disarms_r4: assert property (@(posedge clk) disable iff (rst)
    ack |-> !armed_q);

endmodule

// File: rtl/mgmt_ctrl_regs.sv
module mgmt_ctrl_regs #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_CTRL = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_CTRL-1:0][DATA_W-1:0]  ctrl
);

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_word
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(i);
    always_ff @(posedge clk) begin
      if (rst)
        ctrl[i] <= '0;
      else if (wr_en && wr_addr == WORD_ADDR)
        ctrl[i] <= wr_data;
    end
  end

  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl));

endmodule

// File: rtl/mgmt_read_path.sv
module mgmt_read_path #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_CTRL = 4,
  parameter int STAT_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [NUM_CTRL-1:0][DATA_W-1:0]  ctrl,
  input  logic [STAT_W-1:0]                status_in,
  output logic [DATA_W-1:0]                rd_data
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CTRL);

  logic [STAT_W-1:0] stat_q;
  logic [DATA_W-1:0] sel_word;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= status_in;
  end

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_addr == ADDR_W'(i)) sel_word = ctrl[i];
    if (rd_addr == STAT_ADDR) sel_word = DATA_W'(stat_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_word;
  end

  p_rdata_only_on_read_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/mgmt_reg_slave.sv
module mgmt_reg_slave #(
  parameter int RATE_SEL = mgmt_pkg::RATE_TOP,
  parameter int ADDR_W   = mgmt_pkg::addr_w_for(RATE_SEL),
  parameter int DATA_W   = 32,
  parameter int NUM_CTRL = 4,
  parameter int STAT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_req,
  input  logic              bus_rnw,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [STAT_W-1:0] status_in
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CTRL);

  logic                            accept;
  logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl;

  mgmt_handshake u_hs (
    .clk    (clk),
    .rst    (rst),
    .req    (bus_req),
    .accept (accept),
    .ack    (bus_ack)
  );

  mgmt_ctrl_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_CTRL (NUM_CTRL)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (accept & ~bus_rnw),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .ctrl    (ctrl)
  );

  mgmt_read_path #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_CTRL (NUM_CTRL),
    .STAT_W   (STAT_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (accept & bus_rnw),
    .rd_addr   (bus_addr),
    .ctrl      (ctrl),
    .status_in (status_in),
    .rd_data   (bus_rdata)
  );

  initial begin
    p_addr_width_r8: assert (ADDR_W == mgmt_pkg::addr_w_for(RATE_SEL));
  end

  p_ack_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_req));

  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && $past(bus_rnw) && $past(bus_addr) > STAT_ADDR) |-> bus_rdata == '0);

endmodule

// File: tb/mgmt_reg_slave_bench.sv
`timescale 1ns/1ps
module mgmt_reg_slave_bench;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NC = 4;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_req = 1'b0;
  logic          bus_rnw = 1'b1;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_ack;
  logic [DW-1:0] bus_rdata;
  logic [SW-1:0] status_in = 4'h9;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mgmt_reg_slave #(.RATE_SEL(2), .NUM_CTRL(NC), .STAT_W(SW)) u_mgmt_reg_slave (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_req(bus_req),
    .bus_rnw(bus_rnw), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .status_in(status_in)
  );

  task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hA55A0000 ^ (32'(a) * 32'h01030507);
  endfunction

  // One access: drive at a falling edge, ack is sampled one cycle later
  task automatic access(input logic rnw, input int a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd);
    chk("R1 ack idle before request", 32'(bus_ack), 32'd0);
    bus_addr = AW'(a); bus_rnw = rnw; bus_wdata = wd; bus_req = 1'b1;
    @(negedge clk);
    chk("R1 ack one cycle after request", 32'(bus_ack), 32'd1);
    rd = bus_rdata;
    bus_req = 1'b0;
    @(negedge clk);
    chk("R1 ack single cycle", 32'(bus_ack), 32'd0);
  endtask

  initial begin
    logic [DW-1:0] rd, held, mem [NC];
    repeat (3) @(negedge clk);
    chk("R7 ack cleared by reset", 32'(bus_ack), 32'd0);
    chk("R7 rdata cleared by reset", bus_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      access(1'b1, i, '0, rd);
      chk("R7 control word zero after reset", rd, 32'd0);
    end
    // R2 R5 R6 R8: write every address, then read every address back
    for (int a = 0; a < (1 << AW); a++) access(1'b0, a, pat(a), rd);
    for (int i = 0; i < NC; i++) mem[i] = pat(i);
    for (int a = 0; a < (1 << AW); a++) begin
      access(1'b1, a, '0, rd);
      if (a < NC)       chk("R2 control word readback", rd, mem[a]);
      else if (a == NC) chk("R6 status word read-only", rd, 32'(status_in));
      else              chk("R5 R8 unmapped reads zero", rd, 32'd0);
    end
    // R6: status sweep
    for (int s = 0; s < (1 << SW); s++) begin
      status_in = SW'(s);
      @(negedge clk);
      access(1'b1, NC, '0, rd);
      chk("R6 status mirror", rd, 32'(s));
    end
    // R3: read value held across write and idle cycles
    access(1'b1, 1, '0, held);
    access(1'b0, 1, 32'h0BADF00D, rd);
    chk("R3 rdata held across write", bus_rdata, held);
    repeat (5) @(negedge clk);
    chk("R3 rdata held while idle", bus_rdata, held);
    access(1'b1, 1, '0, rd);
    chk("R2 overwrite readback", rd, 32'h0BADF00D);
    // R4: held request yields one acknowledge
    begin
      int acks = 0;
      bus_addr = AW'(2); bus_rnw = 1'b0; bus_wdata = 32'h12345678; bus_req = 1'b1;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (bus_ack) acks++;
        bus_wdata = 32'hFFFF0000 + 32'(c);
      end
      bus_req = 1'b0;
      @(negedge clk);
      chk("R4 single ack for held request", 32'(acks), 32'd1);
      access(1'b1, 2, '0, rd);
      chk("R4 single write for held request", rd, 32'h12345678);
    end
    // R7: reset mid-run clears words; held request must be re-armed
    bus_req = 1'b1; bus_rnw = 1'b1; bus_addr = AW'(1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 no ack without low request after reset", 32'(bus_ack), 32'd0);
    bus_req = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      access(1'b1, i, '0, rd);
      chk("R7 control word cleared by reset", rd, 32'd0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule